// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit watches every access a core makes (instruction fetches, data reads, data writes and I/O transfers) and compares each one against four linear-address breakpoint registers. Every breakpoint has a two-bit condition field that selects which kind of access it reacts to. Any match is recorded in a sticky status register. The recording happens whether or not the breakpoint is armed. A debug exception request is raised only for breakpoints whose local or global enable bit is set.

Three other things also raise the exception and leave a status bit: a single-step trap, a switch into a task whose trap flag is set, and an attempt to touch the debug registers while register protection is on. Two control bits are cleared by hardware events. The local exact-reporting bit clears on every task switch. The protection bit clears when the debug handler is entered. Status bits are never cleared by hardware. Software clears them by writing the status register.

The access bus is a plain valid-qualified stream with no back-pressure: the unit takes one access per cycle, every cycle. The register port is a simple read/write strobe with a combinational read path.

Top module: `dbg_bp_unit`

## Requirements
- R1: A breakpoint matches only when `acc_valid` is high and `acc_addr` equals its address register in all 32 bits.
- R2: Access kinds are 00 fetch, 01 data write, 10 data read, 11 I/O. The condition values behave as follows: 00 matches fetches only, 01 matches data writes only, and 11 matches data reads and data writes.
- R3: Condition 10 matches I/O accesses only while `dbg_ext_en` is high. While `dbg_ext_en` is low it matches nothing.
- R4: A match of breakpoint n sets status bit n, whether or not breakpoint n is enabled.
- R5: Hardware never clears a status bit. A software write to the status register loads the written value. Only bits 0-3 and 13-15 are implemented; all other status bits read as 0.
- R6: `dbg_exc` is a one-cycle pulse in the cycle after an access that matches breakpoint n, provided control bit 2n (local enable) or 2n+1 (global enable) is set. A match with neither bit set raises no exception.
- R7: While control bit 13 is set, any register read or write sets status bit 13, raises `dbg_exc` in the next cycle, and has its write suppressed.
- R8: A `handler_entry` pulse clears control bit 13.
- R9: A `task_sw` pulse clears control bit 8 and leaves the other control bits unchanged. If `task_trap` is high in the same cycle, status bit 15 is set and `dbg_exc` is raised.
- R10: A `step_trap` pulse sets status bit 14 and raises `dbg_exc`.
- R11: All registers reset to 0. Register selects are: 0-3 for the address registers, 4 for status, 5 for control. Selects 6 and 7 read 0 and ignore writes. Reads are combinational.
- R12: The condition field of breakpoint n occupies control bits 17+4n:16+4n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access on the bus this cycle |
| acc_addr | input | 32 | Linear address of the access |
| acc_kind | input | 2 | 00 fetch, 01 write, 10 read, 11 I/O |
| dbg_ext_en | input | 1 | Debug extensions enabled (I/O breakpoints usable) |
| step_trap | input | 1 | Single-step trap pulse |
| task_sw | input | 1 | Task switch pulse |
| task_trap | input | 1 | Incoming task has its trap flag set (qualifies task_sw) |
| handler_entry | input | 1 | Debug handler entry pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| dbg_exc | output | 1 | Debug exception request pulse |

## Verification
A corrupted address register or condition field appears one cycle after the first access aimed at it, as a missing or extra `dbg_exc` pulse. It also appears at the next status read, as a wrong bit among bits 0-3. A status bit that is lost or wrongly set stays wrong until software rewrites the register, so any later status read exposes it. A control bit that hardware fails to clear shows up when the control register is read back. For the protection bit, it also shows up as an extra exception on the next register access.

// File: rtl/dbgbp_pkg.sv
package dbgbp_pkg;
  // access kinds on the bus
  localparam logic [1:0] KIND_FETCH = 2'b00;
  localparam logic [1:0] KIND_WRITE = 2'b01;
  localparam logic [1:0] KIND_READ  = 2'b10;
  localparam logic [1:0] KIND_IO    = 2'b11;

  // breakpoint condition codes
  localparam logic [1:0] COND_EXEC = 2'b00;
  localparam logic [1:0] COND_WR   = 2'b01;
  localparam logic [1:0] COND_IO   = 2'b10;
  localparam logic [1:0] COND_RW   = 2'b11;

  // control register layout
  localparam int CTL_EXACT_LOCAL = 8;
  localparam int CTL_PROTECT     = 13;
  localparam int COND_BASE       = 16;
  localparam int COND_STRIDE     = 4;

  // status register layout
  localparam int STAT_PROT = 13;
  localparam int STAT_STEP = 14;
  localparam int STAT_TASK = 15;

  function automatic logic cond_hit(input logic [1:0] cond,
                                    input logic [1:0] kind,
                                    input logic       ext_en);
    case (cond)
      COND_EXEC: return kind == KIND_FETCH;
      COND_WR:   return kind == KIND_WRITE;
      COND_IO:   return ext_en && (kind == KIND_IO);
      default:   return (kind == KIND_WRITE) || (kind == KIND_READ);
    endcase
  endfunction
endpackage

// File: rtl/dbgbp_slot.sv
module dbgbp_slot import dbgbp_pkg::*; #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic [1:0]        cond,
  input  logic              ext_en,
  output logic [ADDR_W-1:0] addr_q,
  output logic              hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)     addr_q <= '0;
    else if (wr_en) addr_q <= wdata;
  end

  assign hit = acc_valid && (acc_addr == addr_q) && cond_hit(cond, acc_kind, ext_en);

  assert_exact_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (acc_valid && acc_addr == addr_q));

  assert_io_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == COND_IO && !ext_en) |-> !hit);
endmodule

// File: rtl/dbgbp_status.sv
module dbgbp_status import dbgbp_pkg::*; #(
  parameter int NUM_BP = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic [NUM_BP-1:0] bp_hit,
  input  logic              prot_hit,
  input  logic              step_hit,
  input  logic              task_hit,
  output logic [DATA_W-1:0] stat_q
);
  localparam logic [DATA_W-1:0] BP_MASK   = DATA_W'((1 << NUM_BP) - 1);
  localparam logic [DATA_W-1:0] IMPL_MASK = BP_MASK | (DATA_W'(7) << STAT_PROT);

  logic [DATA_W-1:0] set_vec;

  always_comb begin
    set_vec               = '0;
    set_vec[NUM_BP-1:0]   = bp_hit;
    set_vec[STAT_PROT]    = prot_hit;
    set_vec[STAT_STEP]    = step_hit;
    set_vec[STAT_TASK]    = task_hit;
  end

  // hardware sets win over a same-cycle software write
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((sw_wr ? sw_wdata : stat_q) | set_vec) & IMPL_MASK;
  end

  assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_wr |=> ((stat_q & $past(stat_q)) == $past(stat_q)));

  assert_latch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|bp_hit) |=> ((stat_q[NUM_BP-1:0] & $past(bp_hit)) == $past(bp_hit)));

  assert_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_hit |=> stat_q[STAT_STEP]);
endmodule

// File: rtl/dbg_bp_unit.sv
module dbg_bp_unit import dbgbp_pkg::*; #(
  parameter int NUM_BP = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_kind,
  input  logic              dbg_ext_en,
  input  logic              step_trap,
  input  logic              task_sw,
  input  logic              task_trap,
  input  logic              handler_entry,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              dbg_exc
);
  localparam int SEL_STAT = NUM_BP;
  localparam int SEL_CTRL = NUM_BP + 1;

  logic [DATA_W-1:0] ctrl_q, ctrl_nx, stat_q;
  logic [ADDR_W-1:0] bp_addr [NUM_BP];
  logic [NUM_BP-1:0] bp_hit, bp_armed;
  logic              prot_hit, wr_ok, task_hit;

  assign prot_hit = ctrl_q[CTL_PROTECT] && (reg_wr || reg_rd);
  assign wr_ok    = reg_wr && !ctrl_q[CTL_PROTECT];
  assign task_hit = task_sw && task_trap;

  for (genvar i = 0; i < NUM_BP; i++) begin : g_slot
    dbgbp_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_ok && reg_sel == SEL_W'(i)),
      .wdata     (reg_wdata[ADDR_W-1:0]),
      .acc_valid (acc_valid),
      .acc_addr  (acc_addr),
      .acc_kind  (acc_kind),
      .cond      (ctrl_q[COND_BASE + COND_STRIDE*i +: 2]),
      .ext_en    (dbg_ext_en),
      .addr_q    (bp_addr[i]),
      .hit       (bp_hit[i])
    );
    assign bp_armed[i] = ctrl_q[2*i] | ctrl_q[2*i+1];
  end

  dbgbp_status #(.NUM_BP(NUM_BP), .DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr    (wr_ok && reg_sel == SEL_W'(SEL_STAT)),
    .sw_wdata (reg_wdata),
    .bp_hit   (bp_hit),
    .prot_hit (prot_hit),
    .step_hit (step_trap),
    .task_hit (task_hit),
    .stat_q   (stat_q)
  );

  // control register: software load, then hardware clears take priority
  always_comb begin
    ctrl_nx = (wr_ok && reg_sel == SEL_W'(SEL_CTRL)) ? reg_wdata : ctrl_q;
    if (task_sw)       ctrl_nx[CTL_EXACT_LOCAL] = 1'b0;
    if (handler_entry) ctrl_nx[CTL_PROTECT]     = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      dbg_exc <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_nx;
      dbg_exc <= (|(bp_hit & bp_armed)) | prot_hit | step_trap | task_hit;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_BP; i++)
      if (reg_sel == SEL_W'(i)) reg_rdata = DATA_W'(bp_addr[i]);
    if (reg_sel == SEL_W'(SEL_STAT)) reg_rdata = stat_q;
    if (reg_sel == SEL_W'(SEL_CTRL)) reg_rdata = ctrl_q;
  end

  assert_enabled_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(bp_hit & bp_armed)) |=> dbg_exc);

  assert_protect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[CTL_PROTECT] && (reg_wr || reg_rd)) |=> dbg_exc);

  assert_handler_R8: assert property (@(posedge clk) disable iff (!rst_n)
    handler_entry |=> !ctrl_q[CTL_PROTECT]);

  assert_tasksw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    task_sw |=> !ctrl_q[CTL_EXACT_LOCAL]);
endmodule

// File: tb/tb_dbg_bp_unit.sv
module tb_dbg_bp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic        dbg_ext_en = 1'b0;
  logic        step_trap = 1'b0;
  logic        task_sw = 1'b0;
  logic        task_trap = 1'b0;
  logic        handler_entry = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        dbg_exc;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [31:0] base [4];
  logic [31:0] rv;

  always #10 clk = ~clk;

  dbg_bp_unit dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_kind(acc_kind), .dbg_ext_en(dbg_ext_en), .step_trap(step_trap),
    .task_sw(task_sw), .task_trap(task_trap), .handler_entry(handler_entry),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dbg_exc(dbg_exc)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] sel, output logic [31:0] d);
    reg_rd = 1'b1; reg_sel = sel;
    #1 d = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] k);
    acc_valid = 1'b1; acc_addr = a; acc_kind = k;
    tick();
    acc_valid = 1'b0;
  endtask

  function automatic bit exp_hit(input int c, input int k, input bit e);
    case (c)
      0: return k == 0;
      1: return k == 1;
      2: return (k == 3) && e;
      default: return (k == 1) || (k == 2);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) base[i] = 32'h1357_0000 + i * 32'h0011_2240;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // reset state and register map
    check("R11 exc after reset", {31'd0, dbg_exc}, 32'd0);
    for (int s = 0; s < 8; s++) begin
      rd_reg(3'(s), rv);
      check($sformatf("R11 reset read sel %0d", s), rv, 32'd0);
    end
    for (int i = 0; i < 4; i++) wr_reg(3'(i), base[i]);
    wr_reg(3'd6, 32'hFFFF_FFFF);
    wr_reg(3'd7, 32'hFFFF_FFFF);
    for (int i = 0; i < 4; i++) begin
      rd_reg(3'(i), rv);
      check($sformatf("R11 address readback %0d", i), rv, base[i]);
    end
    rd_reg(3'd6, rv); check("R11 sel 6 reads zero", rv, 32'd0);
    rd_reg(3'd7, rv); check("R11 sel 7 reads zero", rv, 32'd0);

    // sweep: breakpoint x condition x kind x ext enable x arming
    for (int n = 0; n < 4; n++)
      for (int c = 0; c < 4; c++)
        for (int k = 0; k < 4; k++)
          for (int e = 0; e < 2; e++)
            for (int en = 0; en < 3; en++) begin
              logic [31:0] ctl;
              bit h;
              ctl = '0;
              ctl[16 + 4*n +: 2] = 2'(c);
              if (en == 1) ctl[2*n] = 1'b1;
              if (en == 2) ctl[2*n+1] = 1'b1;
              wr_reg(3'd5, ctl);
              wr_reg(3'd4, 32'd0);
              dbg_ext_en = e[0];
              access(base[n], 2'(k));
              h = exp_hit(c, k, e[0]);
              check($sformatf("R6 exc bp%0d cond%0d kind%0d ext%0d en%0d", n, c, k, e, en),
                    {31'd0, dbg_exc}, {31'd0, h && (en != 0)});
              rd_reg(3'd4, rv);
              check($sformatf("R4 R2 R3 R12 status bp%0d cond%0d kind%0d ext%0d en%0d", n, c, k, e, en),
                    rv, h ? (32'd1 << n) : 32'd0);
              if (h && en != 0) begin
                tick();
                check("R6 exc is one cycle", {31'd0, dbg_exc}, 32'd0);
              end
            end
    dbg_ext_en = 1'b0;

    // exact address: every single-bit neighbour misses, invalid access misses
    wr_reg(3'd5, 32'h0003_0001);
    wr_reg(3'd4, 32'd0);
    for (int b = 0; b < 32; b++) begin
      access(base[0] ^ (32'd1 << b), 2'b10);
      check($sformatf("R1 near miss bit %0d exc", b), {31'd0, dbg_exc}, 32'd0);
    end
    acc_addr = base[0]; acc_kind = 2'b10; acc_valid = 1'b0;
    tick();
    check("R1 invalid access no exc", {31'd0, dbg_exc}, 32'd0);
    rd_reg(3'd4, rv); check("R1 no status after misses", rv, 32'd0);
    access(base[0], 2'b10);
    check("R1 exact address hits", {31'd0, dbg_exc}, 32'd1);

    // protection
    wr_reg(3'd4, 32'd0);
    wr_reg(3'd5, 32'h0000_2000);
    check("R7 enabling write itself no exc", {31'd0, dbg_exc}, 32'd0);
    wr_reg(3'd0, 32'hDEAD_BEEF);
    check("R7 guarded write exc", {31'd0, dbg_exc}, 32'd1);
    rd_reg(3'd0, rv); check("R7 write suppressed", rv, base[0]);
    rd_reg(3'd4, rv); check("R7 status bit 13", rv, 32'h0000_2000);
    reg_rd = 1'b1; reg_sel = 3'd1;
    tick();
    reg_rd = 1'b0;
    check("R7 guarded read exc", {31'd0, dbg_exc}, 32'd1);
    wr_reg(3'd4, 32'd0);
    rd_reg(3'd4, rv); check("R7 status write suppressed", rv, 32'h0000_2000);
    handler_entry = 1'b1;
    tick();
    handler_entry = 1'b0;
    rd_reg(3'd5, rv); check("R8 handler clears protect", rv, 32'd0);
    rd_reg(3'd4, rv); check("R5 status 13 sticky over handler", rv, 32'h0000_2000);
    wr_reg(3'd2, 32'hCAFE_0000);
    check("R8 unguarded write no exc", {31'd0, dbg_exc}, 32'd0);
    rd_reg(3'd2, rv); check("R8 unguarded write lands", rv, 32'hCAFE_0000);
    wr_reg(3'd2, base[2]);

    // task switch
    wr_reg(3'd4, 32'd0);
    wr_reg(3'd5, 32'h0000_0355);
    task_sw = 1'b1; task_trap = 1'b0;
    tick();
    task_sw = 1'b0;
    check("R9 plain switch no exc", {31'd0, dbg_exc}, 32'd0);
    rd_reg(3'd5, rv); check("R9 switch clears bit 8 only", rv, 32'h0000_0255);
    rd_reg(3'd4, rv); check("R9 plain switch no status", rv, 32'd0);
    task_sw = 1'b1; task_trap = 1'b1;
    tick();
    task_sw = 1'b0; task_trap = 1'b0;
    check("R9 trapping switch exc", {31'd0, dbg_exc}, 32'd1);
    rd_reg(3'd4, rv); check("R9 status bit 15", rv, 32'h0000_8000);

    // single step
    wr_reg(3'd4, 32'd0);
    step_trap = 1'b1;
    tick();
    step_trap = 1'b0;
    check("R10 step exc", {31'd0, dbg_exc}, 32'd1);
    rd_reg(3'd4, rv); check("R10 status bit 14", rv, 32'h0000_4000);
    repeat (5) tick();
    rd_reg(3'd4, rv); check("R5 status holds while idle", rv, 32'h0000_4000);
    wr_reg(3'd4, 32'hFFFF_FFFF);
    rd_reg(3'd4, rv); check("R5 unimplemented bits read zero", rv, 32'h0000_E00F);
    wr_reg(3'd4, 32'd0);
    rd_reg(3'd4, rv); check("R5 software clear", rv, 32'd0);

    finish_run();
  end
endmodule